// File: doc/BRIEF.md
# Frame Buffer Memory Port Arbiter

This block shares a single 16-bit frame-memory command port between two streams. One side is a write-staging FIFO that collects pixels from a slow, low-frame-rate source. The other side is a display FIFO that feeds a raster generator running at a higher refresh rate. Traffic is driven only by FIFO levels. When the staging FIFO signals almost full, the block drains one burst and stores it. When the display FIFO signals almost empty, the block fetches one burst from memory and pushes it in.

The display side keeps cycling through the stored frame on its own. As a result, the output refresh rate does not depend on how often the source updates. After reset the block first issues the memory start-up command sequence, which includes the refresh interval. Only after that does it allow data traffic. A sticky flag records any read of the display FIFO while that FIFO is empty.

The DRAM protocol engine sits behind the command port. It acknowledges commands, reports busy, takes write words one per cycle after a write is acknowledged, and returns read words with a valid strobe.

Top module: `fb_arbiter`

## Requirements
- R1: After reset the block issues exactly five start-up commands, in this order: precharge (code 1, address 0), refresh (code 2, address 0), refresh (code 2, address 0), mode load (code 3, address = MODE_WORD), refresh-timer set (code 4, address = REFRESH_INTERVAL). No write (code 5) or read (code 6) command is issued and no FIFO is popped or pushed before all five are acknowledged. After reset memCmdValid, inFifoPop, outFifoPush and underrun are 0.
- R2: While memCmdValid is high and memAck is low, memCmd and memAddr hold their values in the next cycle. A new command starts only after the previous transfer has completed.
- R3: When inFifoAlmostFull is high in the idle state, a write command (code 5) is issued. In the BURST_LEN cycles right after its acknowledge, inFifoPop is high and memWrData equals inFifoData, with memWrValid equal to inFifoPop.
- R4: After a read command (code 6) is acknowledged, each of the next BURST_LEN cycles with memRdValid high produces, one cycle later, outFifoPush high with outFifoData equal to the word that was returned.
- R5: When both inFifoAlmostFull and outFifoAlmostEmpty are high as a new request is chosen, the read command is issued first.
- R6: Successive write bursts use addresses FRAME_BASE + k*BURST_LEN. After the last burst of the frame the address wraps to FRAME_BASE. A pulse on inFrameStart makes the next write burst start at FRAME_BASE.
- R7: Successive read bursts use addresses FRAME_BASE + k*BURST_LEN and wrap to FRAME_BASE after the last burst of the frame. Writes and frame starts have no effect on the read address.
- R8: underrun becomes 1 in the cycle after dispRead and outFifoEmpty are both high. It stays 1 until reset. A dispRead while outFifoEmpty is low leaves it unchanged.
- R9: While memBusy is high in the idle or start-up gap state, no new command is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inFrameStart | input | 1 | Start-of-frame pulse from the input side |
| inFifoAlmostFull | input | 1 | Staging FIFO level at or above threshold |
| inFifoData | input | DATA_W | Head word of the staging FIFO (show-ahead) |
| inFifoPop | output | 1 | Pop the staging FIFO |
| memWrData | output | DATA_W | Write word to the memory engine |
| memWrValid | output | 1 | Write word valid |
| outFifoAlmostEmpty | input | 1 | Display FIFO level at or below threshold |
| outFifoEmpty | input | 1 | Display FIFO empty |
| dispRead | input | 1 | Display reads the display FIFO |
| outFifoPush | output | 1 | Push into the display FIFO |
| outFifoData | output | DATA_W | Word pushed into the display FIFO |
| underrun | output | 1 | Sticky display underrun flag |
| memBusy | input | 1 | Memory engine busy; no new command may start |
| memCmdValid | output | 1 | Command request |
| memCmd | output | 3 | Command code |
| memAddr | output | ADDR_W | Command address (word units) |
| memAck | input | 1 | Command accepted this cycle |
| memRdValid | input | 1 | Read word valid |
| memRdData | input | DATA_W | Read word |

## Verification
The bench builds the block with BURST_LEN = 4, FRAME_WORDS = 16, FRAME_BASE = 32 and ADDR_W = 12, so a frame holds only four bursts. With these values, the write-pointer wrap and the restart on inFrameStart are both reached within a handful of bursts, and the read-pointer wrap is reached within five read bursts. The memory model acknowledges with latencies of zero to two cycles, which exercises command hold. A phase holds memBusy high while both FIFO thresholds are raised, and that phase covers the busy gate and the read-first priority together.

// File: rtl/fb_arb_pkg.sv
package fb_arb_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_PRECHARGE = 3'd1,
    CMD_REFRESH   = 3'd2,
    CMD_LOAD_MODE = 3'd3,
    CMD_SET_TIMER = 3'd4,
    CMD_WRITE     = 3'd5,
    CMD_READ      = 3'd6
  } memCmd_e;

  typedef enum logic [1:0] {
    ADDR_INIT = 2'd0,
    ADDR_WR   = 2'd1,
    ADDR_RD   = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     wrRewind;
    logic     wrAdvance;
    logic     rdAdvance;
    logic     rdBeat;
    addrSel_e addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/fb_arb_ctrl.sv
module fb_arb_ctrl
  import fb_arb_pkg::*;
#(
  parameter int ADDR_W           = 22,
  parameter int BURST_LEN        = 8,
  parameter int MODE_WORD        = 'h033,
  parameter int REFRESH_INTERVAL = 390
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inFrameStart,
  input  logic              inFifoAlmostFull,
  input  logic              outFifoAlmostEmpty,
  input  logic              memBusy,
  input  logic              memAck,
  input  logic              memRdValid,
  output logic              memCmdValid,
  output logic [2:0]        memCmd,
  output logic [ADDR_W-1:0] initAddr,
  output logic              inFifoPop,
  output logic              initBusy,
  output ctrlStrobe_t       strobe
);

  localparam int INIT_STEPS = 5;
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  typedef enum logic [2:0] {
    ST_INIT_GAP, ST_INIT_REQ, ST_IDLE, ST_WR_REQ, ST_WR_DATA, ST_RD_REQ, ST_RD_DATA
  } state_e;

  state_e            state, stateNext;
  logic [2:0]        initIdx;
  logic [BEAT_W-1:0] beatCnt;
  logic              restartPend;
  memCmd_e           initCmd;

  always_comb begin
    initCmd  = CMD_NOP;
    initAddr = '0;
    case (initIdx)
      3'd0:      initCmd = CMD_PRECHARGE;
      3'd1,
      3'd2:      initCmd = CMD_REFRESH;
      3'd3: begin
        initCmd  = CMD_LOAD_MODE;
        initAddr = ADDR_W'(MODE_WORD);
      end
      3'd4: begin
        initCmd  = CMD_SET_TIMER;
        initAddr = ADDR_W'(REFRESH_INTERVAL);
      end
      default: initCmd = CMD_NOP;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_INIT_GAP: if (!memBusy)
                     stateNext = (initIdx == 3'(INIT_STEPS)) ? ST_IDLE : ST_INIT_REQ;
      ST_INIT_REQ: if (memAck) stateNext = ST_INIT_GAP;
      ST_IDLE: if (!memBusy) begin
                 if (outFifoAlmostEmpty)    stateNext = ST_RD_REQ;
                 else if (inFifoAlmostFull) stateNext = ST_WR_REQ;
               end
      ST_WR_REQ:  if (memAck) stateNext = ST_WR_DATA;
      ST_WR_DATA: if (beatCnt == LAST_BEAT) stateNext = ST_IDLE;
      ST_RD_REQ:  if (memAck) stateNext = ST_RD_DATA;
      ST_RD_DATA: if (memRdValid && beatCnt == LAST_BEAT) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_INIT_GAP;
      initIdx     <= '0;
      beatCnt     <= '0;
      restartPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_INIT_REQ && memAck) initIdx <= initIdx + 3'd1;
      if (state == ST_WR_REQ || state == ST_RD_REQ) beatCnt <= '0;
      else if (state == ST_WR_DATA || (state == ST_RD_DATA && memRdValid))
        beatCnt <= beatCnt + 1'b1;
      if (state == ST_IDLE)  restartPend <= 1'b0;
      else if (inFrameStart) restartPend <= 1'b1;
    end
  end

  always_comb begin
    memCmdValid = (state == ST_INIT_REQ) || (state == ST_WR_REQ) || (state == ST_RD_REQ);
    case (state)
      ST_INIT_REQ: memCmd = initCmd;
      ST_WR_REQ:   memCmd = CMD_WRITE;
      ST_RD_REQ:   memCmd = CMD_READ;
      default:     memCmd = CMD_NOP;
    endcase
    inFifoPop        = (state == ST_WR_DATA);
    initBusy         = (state == ST_INIT_GAP) || (state == ST_INIT_REQ);
    strobe.wrRewind  = (state == ST_IDLE) && (restartPend || inFrameStart);
    strobe.wrAdvance = (state == ST_WR_REQ) && memAck;
    strobe.rdAdvance = (state == ST_RD_REQ) && memAck;
    strobe.rdBeat    = (state == ST_RD_DATA) && memRdValid;
    strobe.addrSel   = (state == ST_WR_REQ) ? ADDR_WR :
                       (state == ST_RD_REQ) ? ADDR_RD : ADDR_INIT;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && !memAck |=> memCmdValid && $stable(memCmd)); // R2

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_INIT_GAP) && memBusy |=> !memCmdValid); // R9

  AST_INIT_NO_DATA_CMD: assert property (@(posedge clk) disable iff (!rstN)
    initBusy && memCmdValid |-> memCmd != CMD_WRITE && memCmd != CMD_READ); // R1

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE && !memBusy && outFifoAlmostEmpty |=> memCmd == CMD_READ); // R5

endmodule

// File: rtl/fb_arb_dpath.sv
module fb_arb_dpath
  import fb_arb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 22,
  parameter int BURST_LEN   = 8,
  parameter int FRAME_WORDS = 393216,
  parameter int FRAME_BASE  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              dispRead,
  input  logic              outFifoEmpty,
  output logic [ADDR_W-1:0] memAddr,
  output logic              outFifoPush,
  output logic [DATA_W-1:0] outFifoData,
  output logic              underrun
);

  localparam int OFF_W = $clog2(FRAME_WORDS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(FRAME_WORDS - BURST_LEN);
  localparam logic [OFF_W-1:0] STEP     = OFF_W'(BURST_LEN);
  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(FRAME_BASE);

  logic [OFF_W-1:0] wrOff, rdOff;

  function automatic logic [OFF_W-1:0] nextOff(input logic [OFF_W-1:0] off);
    return (off == LAST_OFF) ? '0 : off + STEP;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrOff       <= '0;
      rdOff       <= '0;
      outFifoPush <= 1'b0;
      outFifoData <= '0;
      underrun    <= 1'b0;
    end else begin
      if (strobe.wrRewind)       wrOff <= '0;
      else if (strobe.wrAdvance) wrOff <= nextOff(wrOff);
      if (strobe.rdAdvance)      rdOff <= nextOff(rdOff);
      outFifoPush <= strobe.rdBeat;
      if (strobe.rdBeat) outFifoData <= memRdData;
      if (dispRead && outFifoEmpty) underrun <= 1'b1;
    end
  end

  always_comb begin
    case (strobe.addrSel)
      ADDR_WR: memAddr = BASE + ADDR_W'(wrOff);
      ADDR_RD: memAddr = BASE + ADDR_W'(rdOff);
      default: memAddr = initAddr;
    endcase
  end

  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addrSel != ADDR_INIT |->
      memAddr >= BASE && memAddr <= BASE + ADDR_W'(LAST_OFF)); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun); // R8

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    dispRead && outFifoEmpty |=> underrun); // R8

endmodule

// File: rtl/fb_arbiter.sv
module fb_arbiter
  import fb_arb_pkg::*;
#(
  parameter int DATA_W           = 16,
  parameter int ADDR_W           = 22,
  parameter int BURST_LEN        = 8,
  parameter int FRAME_WORDS      = 393216,
  parameter int FRAME_BASE       = 0,
  parameter int MODE_WORD        = 'h033,
  parameter int REFRESH_INTERVAL = 390
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inFrameStart,
  input  logic              inFifoAlmostFull,
  input  logic [DATA_W-1:0] inFifoData,
  output logic              inFifoPop,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrValid,
  input  logic              outFifoAlmostEmpty,
  input  logic              outFifoEmpty,
  input  logic              dispRead,
  output logic              outFifoPush,
  output logic [DATA_W-1:0] outFifoData,
  output logic              underrun,
  input  logic              memBusy,
  output logic              memCmdValid,
  output logic [2:0]        memCmd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] initAddr;
  logic              initBusy;

  fb_arb_ctrl #(
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .MODE_WORD(MODE_WORD), .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inFrameStart(inFrameStart),
    .inFifoAlmostFull(inFifoAlmostFull), .outFifoAlmostEmpty(outFifoAlmostEmpty),
    .memBusy(memBusy), .memAck(memAck), .memRdValid(memRdValid),
    .memCmdValid(memCmdValid), .memCmd(memCmd), .initAddr(initAddr),
    .inFifoPop(inFifoPop), .initBusy(initBusy), .strobe(strobe)
  );

  fb_arb_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .FRAME_WORDS(FRAME_WORDS), .FRAME_BASE(FRAME_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .initAddr(initAddr),
    .memRdData(memRdData), .dispRead(dispRead), .outFifoEmpty(outFifoEmpty),
    .memAddr(memAddr), .outFifoPush(outFifoPush), .outFifoData(outFifoData),
    .underrun(underrun)
  );

  assign memWrData  = inFifoData;
  assign memWrValid = inFifoPop;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid && !memAck |=> $stable(memAddr)); // R2

  AST_NO_DATA_IN_INIT: assert property (@(posedge clk) disable iff (!rstN)
    initBusy |-> !inFifoPop && !outFifoPush); // R1

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    !(inFifoPop && outFifoPush)); // R3

endmodule

// File: tb/fb_arbiter_tb.sv
module fb_arbiter_tb;

  localparam int DW = 16, AW = 12, BL = 4, FW = 16, FB = 32;
  localparam int MODEW = 'h033, REFI = 'h187;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, inFrameStart, inFifoAlmostFull, inFifoPop, memWrValid;
  logic outFifoAlmostEmpty, outFifoEmpty, dispRead, outFifoPush, underrun;
  logic memBusy, memCmdValid, memAck, memRdValid;
  logic [DW-1:0] inFifoData, memWrData, outFifoData, memRdData;
  logic [2:0] memCmd;
  logic [AW-1:0] memAddr;

  fb_arbiter #(
    .DATA_W(DW), .ADDR_W(AW), .BURST_LEN(BL), .FRAME_WORDS(FW), .FRAME_BASE(FB),
    .MODE_WORD(MODEW), .REFRESH_INTERVAL(REFI)
  ) u_dut (.*);

  typedef struct { logic [2:0] cmd; logic [AW-1:0] addr; string tag; } expCmd_t;
  expCmd_t cmdQ[$];
  logic [DW-1:0] rdQ[$];

  int total = 0, bad = 0;
  int wrAcc = 0, rdAcc = 0, allAcc = 0, pops = 0, pushes = 0;
  int ackLat = 0, waitCnt = 0, rdLeft = 0;
  logic [AW-1:0] rdAddr;
  logic heldPrev = 1'b0;
  logic [2:0] prevCmd;
  logic [AW-1:0] prevAddr;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectCmd(input logic [2:0] c, input int a, input string tag);
    expCmd_t e;
    e.cmd = c; e.addr = AW'(a); e.tag = tag;
    cmdQ.push_back(e);
  endtask

  // staging FIFO model: head word advances on each pop
  always @(posedge clk) if (inFifoPop) inFifoData <= inFifoData + 16'd1;

  // memory engine model and command monitor
  always @(negedge clk) begin
    if (rdLeft > 0) begin
      memRdValid = 1'b1; memRdData = 16'hA000 + DW'(rdAddr);
      rdQ.push_back(memRdData);
      rdAddr = rdAddr + 1'b1; rdLeft--;
    end else memRdValid = 1'b0;

    if (heldPrev && memCmdValid)
      check(memCmd == prevCmd && memAddr == prevAddr, "R2 hold", {memCmd, memAddr}, {prevCmd, prevAddr});

    if (memAck) memAck = 1'b0;
    else if (memCmdValid) begin
      if (waitCnt >= ackLat) begin
        expCmd_t e;
        memAck = 1'b1; waitCnt = 0; allAcc++;
        if (cmdQ.size() == 0) check(1'b0, "R2 unexpected command", {memCmd, memAddr}, 0);
        else begin
          e = cmdQ.pop_front();
          check(memCmd == e.cmd && memAddr == e.addr, e.tag, {memCmd, memAddr}, {e.cmd, e.addr});
        end
        if (memCmd == 3'd5) wrAcc++;
        if (memCmd == 3'd6) begin rdAcc++; rdLeft = BL; rdAddr = memAddr; end
      end else waitCnt++;
    end
    heldPrev = memCmdValid && !memAck;
    prevCmd = memCmd; prevAddr = memAddr;
  end

  // data monitors
  always @(negedge clk) begin
    if (rstN && inFifoPop) begin
      pops++;
      check(memWrValid && memWrData == inFifoData, "R3 write word", memWrData, inFifoData);
    end
    if (rstN && outFifoPush) begin
      logic [DW-1:0] exp;
      pushes++;
      exp = (rdQ.size() > 0) ? rdQ.pop_front() : 16'hXXXX;
      check(outFifoData == exp, "R4 display word", outFifoData, exp);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; inFrameStart = 1'b0; inFifoAlmostFull = 1'b0; inFifoData = 16'h0100;
    outFifoAlmostEmpty = 1'b0; outFifoEmpty = 1'b0; dispRead = 1'b0;
    memBusy = 1'b1; memAck = 1'b0; memRdValid = 1'b0; memRdData = '0;
    idle(3);
    check(!memCmdValid && !inFifoPop && !outFifoPush, "R1 reset outputs", {memCmdValid, inFifoPop, outFifoPush}, 0);
    check(!underrun, "R8 reset underrun", underrun, 0);
    rstN = 1'b1;
    for (int i = 0; i < 10; i++) begin
      idle(1);
      check(!memCmdValid, "R9 busy holds start-up", memCmdValid, 0);
    end
    // start-up sequence, acknowledged after two waiting cycles
    ackLat = 2;
    expectCmd(3'd1, 0, "R1 init 0");
    expectCmd(3'd2, 0, "R1 init 1");
    expectCmd(3'd2, 0, "R1 init 2");
    expectCmd(3'd3, MODEW, "R1 init 3");
    expectCmd(3'd4, REFI, "R1 init 4");
    memBusy = 1'b0;
    while (allAcc < 5) idle(1);
    idle(6);
    check(allAcc == 5, "R1 init count", allAcc, 5);

    // write bursts with wrap at end of frame
    ackLat = 0;
    for (int k = 0; k < 5; k++) expectCmd(3'd5, FB + (k % 4) * BL, "R6 write addr");
    inFifoAlmostFull = 1'b1;
    while (wrAcc < 5) idle(1);
    idle(1); inFifoAlmostFull = 1'b0;
    idle(12);
    check(pops == 5 * BL, "R3 pop count", pops, 5 * BL);

    // frame start rewinds the write pointer
    inFrameStart = 1'b1; idle(1); inFrameStart = 1'b0;
    expectCmd(3'd5, FB, "R6 restart at base");
    inFifoAlmostFull = 1'b1;
    while (wrAcc < 6) idle(1);
    idle(1); inFifoAlmostFull = 1'b0;
    idle(12);

    // read bursts, wrap back to base
    ackLat = 1;
    for (int k = 0; k < 5; k++) expectCmd(3'd6, FB + (k % 4) * BL, "R7 read addr");
    outFifoAlmostEmpty = 1'b1;
    while (rdAcc < 5) idle(1);
    idle(1); outFifoAlmostEmpty = 1'b0;
    idle(12);
    check(pushes == 5 * BL, "R4 push count", pushes, 5 * BL);

    // both pending under busy: nothing starts, then read goes first
    memBusy = 1'b1; inFifoAlmostFull = 1'b1; outFifoAlmostEmpty = 1'b1;
    for (int i = 0; i < 8; i++) begin
      idle(1);
      check(!memCmdValid, "R9 busy blocks request", memCmdValid, 0);
    end
    expectCmd(3'd6, FB + BL, "R5 read first");
    expectCmd(3'd5, FB + BL, "R5 write second");
    memBusy = 1'b0;
    while (rdAcc < 6) idle(1);
    idle(1); outFifoAlmostEmpty = 1'b0;
    while (wrAcc < 7) idle(1);
    idle(1); inFifoAlmostFull = 1'b0;
    idle(12);
    check(pops == 7 * BL, "R3 pop count after priority", pops, 7 * BL);
    check(pushes == 6 * BL, "R4 push count after priority", pushes, 6 * BL);

    // underrun flag
    dispRead = 1'b1; outFifoEmpty = 1'b0; idle(1);
    dispRead = 1'b0; idle(1);
    check(!underrun, "R8 read while not empty", underrun, 0);
    dispRead = 1'b1; outFifoEmpty = 1'b1; idle(1);
    dispRead = 1'b0; outFifoEmpty = 1'b0;
    check(underrun, "R8 underrun set", underrun, 1);
    idle(5);
    check(underrun, "R8 underrun sticky", underrun, 1);

    check(cmdQ.size() == 0, "R2 all expected commands seen", cmdQ.size(), 0);
    check(rdQ.size() == 0, "R4 all read words pushed", rdQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule